// File: doc/BRIEF.md
# AXI Address-Channel Request Legality Checker

This block is a passive observer placed on one AXI address channel, either read or write. It drives nothing back onto the bus. On every accepted transfer, meaning a clock edge where valid and ready are both high, it checks the request fields against a fixed set of interface capabilities. Those capabilities are the data bus width, a ceiling on the bytes one transaction may move, a switch that forbids FIXED bursts, and a switch that restricts traffic to a regular profile. The regular profile allows only power-of-two burst lengths, full-width beats and aligned addresses. The block also checks the rules for memory-tag operations.

Each rule owns one sticky flag. A flag is set by the first transfer that breaks its rule and stays set until reset. A one-cycle error strobe marks every transfer that broke at least one rule. A saturating counter tallies those bad transfers. Integration monitors and bring-up logic can read the flags to see which capability a requester broke, without reading back any traffic.

Top module: `axi_req_checker`

## Requirements
- R1: Flag bit 0 sets when the beat size 2^size in bytes is larger than the bus width DATA_W/8.
- R2: Flag bit 1 sets when (len+1)·2^size is larger than MAX_XACT_BYTES.
- R3: Burst codes are FIXED=0, INCR=1, WRAP=2 and reserved=3. Flag bit 2 sets for FIXED when NO_FIXED or REGULAR_ONLY is 1. Flag bit 3 sets for burst code 3 in every mode.
- R4: With REGULAR_ONLY=1, flag bit 4 sets when len is not one of 0, 1, 3, 7 or 15.
- R5: With REGULAR_ONLY=1, flag bit 5 sets when len is not 0 and 2^size differs from the bus width in bytes.
- R6: With REGULAR_ONLY=1 and len in the allowed set, flag bit 6 sets in two cases. The first is an INCR burst whose address is not a multiple of (len+1)·2^size. The second is a WRAP burst whose address is not a multiple of 2^size.
- R7: When tagop is nonzero, three flags may set. Flag bit 7 sets for a FIXED burst. Flag bit 8 sets when cache[3:0] is not 4'b0011. Flag bit 9 sets when HAS_IDUNQ=1 and idunq is not 1.
- R8: With IS_READ=1, flag bit 10 sets when tagop equals 2'b10.
- R9: When valid and ready are not both high at an edge, the flags, the counter and the strobe stay as they were (the strobe stays low).
- R10: The flags are sticky. They update at the accepting edge and are visible after it. err_pulse is high for exactly the cycle after each accepted transfer that broke at least one rule.
- R11: err_count adds one for each accepted transfer that broke at least one rule. It saturates at 2^CNT_W-1.
- R12: An active-low reset clears all flags, the strobe and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address channel valid |
| req_ready | input | 1 | Address channel ready |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | 8 | Beats minus one |
| req_size | input | 3 | log2 of beat bytes |
| req_burst | input | 2 | Burst type code |
| req_cache | input | 4 | Cache attributes |
| req_tagop | input | 2 | Memory-tag operation |
| req_idunq | input | 1 | Unique-ID indication |
| viol_flags | output | 11 | Sticky per-rule violation flags |
| err_pulse | output | 1 | One-cycle strobe after a bad transfer |
| err_count | output | CNT_W | Saturating count of bad transfers |

## Verification
A wrong rule decode appears at the ports one cycle after the accepting edge. It shows as a flag vector that differs from the one predicted from the fields. A lost sticky bit or a transfer that should have been ignored shows in the same cycle after the next edge, as flags or a count that moved or cleared. A counter that wraps instead of saturating shows only once the count reaches its top value, so the bench pushes the count past that value with a narrow counter. The bench resets the block every few random requests, so each check compares the flags against only a handful of accumulated requests.

// File: rtl/axi_chk_pkg.sv
package axi_chk_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;

  localparam int NUM_RULES      = 11;
  localparam int RULE_SIZE_WIDE = 0;
  localparam int RULE_TOO_BIG   = 1;
  localparam int RULE_FIXED_OFF = 2;
  localparam int RULE_RSVD_BRST = 3;
  localparam int RULE_REG_LEN   = 4;
  localparam int RULE_REG_SIZE  = 5;
  localparam int RULE_REG_ALIGN = 6;
  localparam int RULE_TAG_BURST = 7;
  localparam int RULE_TAG_CACHE = 8;
  localparam int RULE_TAG_UNQ   = 9;
  localparam int RULE_TAG_RSVD  = 10;
endpackage

// File: rtl/axi_chk_rules.sv
module axi_chk_rules
  import axi_chk_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int MAX_XACT_BYTES = 4096,
  parameter bit NO_FIXED       = 1'b0,
  parameter bit REGULAR_ONLY   = 1'b0,
  parameter bit IS_READ        = 1'b1,
  parameter bit HAS_IDUNQ      = 1'b1,
  parameter int ADDR_W         = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           len,
  input  logic [2:0]           size,
  input  logic [1:0]           burst,
  input  logic [3:0]           cache,
  input  logic [1:0]           tagop,
  input  logic                 idunq,
  output logic [NUM_RULES-1:0] hits
);
  localparam int BUS_BYTES = DATA_W / 8;
  localparam int TOT_W     = 17;

  logic [TOT_W-1:0]  beat_bytes;
  logic [TOT_W-1:0]  total_bytes;
  logic [ADDR_W-1:0] incr_mask;
  logic [ADDR_W-1:0] wrap_mask;
  logic              len_regular;
  logic              tag_on;
  burst_e            btype;

  always_comb begin
    btype       = burst_e'(burst);
    beat_bytes  = TOT_W'(1) << size;
    total_bytes = (TOT_W'(len) + TOT_W'(1)) << size;
    incr_mask   = ADDR_W'(total_bytes - TOT_W'(1));
    wrap_mask   = ADDR_W'(beat_bytes - TOT_W'(1));
    len_regular = (len == 8'd0) || (len == 8'd1) || (len == 8'd3) ||
                  (len == 8'd7) || (len == 8'd15);
    tag_on      = (tagop != 2'b00);

    hits = '0;
    hits[RULE_SIZE_WIDE] = beat_bytes > TOT_W'(BUS_BYTES);
    hits[RULE_TOO_BIG]   = int'(total_bytes) > MAX_XACT_BYTES;
    hits[RULE_FIXED_OFF] = (NO_FIXED || REGULAR_ONLY) && (btype == BURST_FIXED);
    hits[RULE_RSVD_BRST] = (btype == BURST_RSVD);
    hits[RULE_REG_LEN]   = REGULAR_ONLY && !len_regular;
    hits[RULE_REG_SIZE]  = REGULAR_ONLY && (len != 8'd0) &&
                           (beat_bytes != TOT_W'(BUS_BYTES));
    if (REGULAR_ONLY && len_regular) begin
      if (btype == BURST_INCR)
        hits[RULE_REG_ALIGN] = (addr & incr_mask) != '0;
      else if (btype == BURST_WRAP)
        hits[RULE_REG_ALIGN] = (addr & wrap_mask) != '0;
    end
    hits[RULE_TAG_BURST] = tag_on && (btype == BURST_FIXED);
    hits[RULE_TAG_CACHE] = tag_on && (cache != 4'b0011);
    hits[RULE_TAG_UNQ]   = HAS_IDUNQ && tag_on && !idunq;
    hits[RULE_TAG_RSVD]  = IS_READ && (tagop == 2'b10);
  end
endmodule

// File: rtl/axi_chk_sticky.sv
module axi_chk_sticky #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [N-1:0] hits,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      flags_d[g] = flags[g];
      if (capture && hits[g]) flags_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags[g] <= 1'b0;
      else if (capture) flags[g] <= flags_d[g];
    end
  end
endmodule

// File: rtl/axi_chk_counter.sv
module axi_chk_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = inc && (count != CNT_MAX);
    count_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= count_d;
  end
endmodule

// File: rtl/axi_req_checker.sv
module axi_req_checker
  import axi_chk_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int MAX_XACT_BYTES = 4096,
  parameter bit NO_FIXED       = 1'b0,
  parameter bit REGULAR_ONLY   = 1'b0,
  parameter bit IS_READ        = 1'b1,
  parameter bit HAS_IDUNQ      = 1'b1,
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [7:0]           req_len,
  input  logic [2:0]           req_size,
  input  logic [1:0]           req_burst,
  input  logic [3:0]           req_cache,
  input  logic [1:0]           req_tagop,
  input  logic                 req_idunq,
  output logic [NUM_RULES-1:0] viol_flags,
  output logic                 err_pulse,
  output logic [CNT_W-1:0]     err_count
);
  logic [NUM_RULES-1:0] rule_hits;
  logic                 accept;
  logic                 bad_req;
  logic                 pulse_d;

  always_comb begin
    accept  = req_valid && req_ready;
    bad_req = accept && (rule_hits != '0);
    pulse_d = bad_req;
  end

  axi_chk_rules #(
    .DATA_W(DATA_W), .MAX_XACT_BYTES(MAX_XACT_BYTES), .NO_FIXED(NO_FIXED),
    .REGULAR_ONLY(REGULAR_ONLY), .IS_READ(IS_READ), .HAS_IDUNQ(HAS_IDUNQ),
    .ADDR_W(ADDR_W)
  ) u_rules (
    .addr(req_addr), .len(req_len), .size(req_size), .burst(req_burst),
    .cache(req_cache), .tagop(req_tagop), .idunq(req_idunq), .hits(rule_hits)
  );

  axi_chk_sticky #(.N(NUM_RULES)) u_sticky (
    .clk(clk), .rst_n(rst_n), .capture(accept), .hits(rule_hits), .flags(viol_flags)
  );

  axi_chk_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(bad_req), .count(err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= pulse_d;
  end
endmodule

// File: rtl/axi_req_checker_sva.sv
module axi_req_checker_sva #(
  parameter int NUM_RULES = 11,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_burst,
  input logic [NUM_RULES-1:0] viol_flags,
  input logic                 err_pulse,
  input logic [CNT_W-1:0]     err_count
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> ($stable(viol_flags) && $stable(err_count) && !err_pulse)); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol_flags & $past(viol_flags)) == $past(viol_flags))); // R10

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(req_valid && req_ready) && (viol_flags != '0))); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == $past(err_count)) || (err_count == $past(err_count) + CNT_W'(1))); // R11

  AST_RSVD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_burst == 2'b11)) |=> viol_flags[3]); // R3
endmodule

bind axi_req_checker axi_req_checker_sva #(
  .NUM_RULES(axi_chk_pkg::NUM_RULES), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_burst(req_burst), .viol_flags(viol_flags), .err_pulse(err_pulse),
  .err_count(err_count)
);

// File: tb/test_axi_req_checker.sv
module test_axi_req_checker;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int MAXB = 128;
  localparam int AW = 32;
  localparam int CW = 3;
  localparam int NR = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_idunq;
  logic [AW-1:0] req_addr;
  logic [7:0] req_len;
  logic [2:0] req_size;
  logic [1:0] req_burst, req_tagop;
  logic [3:0] req_cache;
  logic [NR-1:0] viol_flags;
  logic err_pulse;
  logic [CW-1:0] err_count;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [NR-1:0] exp_flags;
  int exp_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_req_checker #(
    .DATA_W(DW), .MAX_XACT_BYTES(MAXB), .NO_FIXED(1'b0), .REGULAR_ONLY(1'b1),
    .IS_READ(1'b1), .HAS_IDUNQ(1'b1), .ADDR_W(AW), .CNT_W(CW)
  ) i_axi_req_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
    .req_burst(req_burst), .req_cache(req_cache), .req_tagop(req_tagop),
    .req_idunq(req_idunq), .viol_flags(viol_flags), .err_pulse(err_pulse),
    .err_count(err_count)
  );

  function automatic logic [NR-1:0] model(input logic [AW-1:0] a, input logic [7:0] l,
      input logic [2:0] s, input logic [1:0] b, input logic [3:0] c,
      input logic [1:0] t, input logic u);
    logic [NR-1:0] r;
    longint beat, tot;
    bit lreg;
    beat = longint'(1) << s;
    tot  = (longint'(l) + 1) * beat;
    lreg = (l == 0) || (l == 1) || (l == 3) || (l == 7) || (l == 15);
    r = '0;
    r[0]  = beat > DW/8;                                      // R1
    r[1]  = tot > MAXB;                                       // R2
    r[2]  = (b == 2'd0);                                      // R3 regular mode
    r[3]  = (b == 2'd3);                                      // R3
    r[4]  = !lreg;                                            // R4
    r[5]  = (l != 0) && (beat != DW/8);                       // R5
    if (lreg && b == 2'd1) r[6] = (longint'(a) % tot) != 0;   // R6
    if (lreg && b == 2'd2) r[6] = (longint'(a) % beat) != 0;  // R6
    r[7]  = (t != 0) && (b == 2'd0);                          // R7
    r[8]  = (t != 0) && (c != 4'b0011);                       // R7
    r[9]  = (t != 0) && !u;                                   // R7
    r[10] = (t == 2'b10);                                     // R8
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit exp_pulse);
    check(viol_flags == exp_flags, req, "flags", longint'(viol_flags), longint'(exp_flags));
    check(err_count == CW'(exp_cnt), req, "count", longint'(err_count), longint'(exp_cnt));
    check(err_pulse == exp_pulse, req, "pulse", longint'(err_pulse), longint'(exp_pulse));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    exp_flags = '0; exp_cnt = 0;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [7:0] l, input logic [2:0] s,
      input logic [1:0] b, input logic [3:0] c, input logic [1:0] t, input logic u,
      input logic v, input logic rd, input string req);
    logic [NR-1:0] h;
    bit p;
    req_addr = a; req_len = l; req_size = s; req_burst = b;
    req_cache = c; req_tagop = t; req_idunq = u;
    req_valid = v; req_ready = rd;
    h = model(a, l, s, b, c, t, u);
    @(posedge clk); @(negedge clk);
    p = 1'b0;
    if (v && rd) begin
      exp_flags |= h;
      if (h != '0) begin
        p = 1'b1;
        if (exp_cnt < (1 << CW) - 1) exp_cnt++;
      end
    end
    check_all(req, p);
    req_valid = 1'b0; req_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    req_addr = '0; req_len = '0; req_size = '0; req_burst = '0;
    req_cache = '0; req_tagop = '0; req_idunq = 1'b0;
    do_reset();
    check_all("R12", 1'b0);
    send(32'h40, 8'd3, 3'd3, 2'd1, 4'b0011, 2'd0, 1'b1, 1, 1, "R10");
    send(32'h0, 8'd0, 3'd4, 2'd1, 4'b0000, 2'd0, 1'b0, 1, 1, "R1");
    do_reset();
    send(32'h0, 8'd31, 3'd3, 2'd1, 4'b0000, 2'd0, 1'b0, 1, 1, "R2");
    do_reset();
    send(32'h0, 8'd1, 3'd3, 2'd0, 4'b0000, 2'd0, 1'b0, 1, 1, "R3");
    send(32'h0, 8'd1, 3'd3, 2'd3, 4'b0000, 2'd0, 1'b0, 1, 1, "R3");
    do_reset();
    send(32'h0, 8'd2, 3'd3, 2'd1, 4'b0000, 2'd0, 1'b0, 1, 1, "R4");
    do_reset();
    send(32'h0, 8'd1, 3'd2, 2'd1, 4'b0000, 2'd0, 1'b0, 1, 1, "R5");
    do_reset();
    send(32'h8, 8'd3, 3'd3, 2'd1, 4'b0000, 2'd0, 1'b0, 1, 1, "R6");
    do_reset();
    send(32'h8, 8'd3, 3'd3, 2'd2, 4'b0000, 2'd0, 1'b0, 1, 1, "R6");
    send(32'h4, 8'd3, 3'd3, 2'd2, 4'b0000, 2'd0, 1'b0, 1, 1, "R6");
    do_reset();
    send(32'h0, 8'd0, 3'd3, 2'd0, 4'b0011, 2'd1, 1'b1, 1, 1, "R7");
    do_reset();
    send(32'h0, 8'd0, 3'd3, 2'd1, 4'b0111, 2'd3, 1'b0, 1, 1, "R7");
    do_reset();
    send(32'h0, 8'd0, 3'd3, 2'd1, 4'b0011, 2'd2, 1'b1, 1, 1, "R8");
    do_reset();
    send(32'h4, 8'd9, 3'd7, 2'd3, 4'b0, 2'd2, 1'b0, 1, 0, "R9");
    send(32'h4, 8'd9, 3'd7, 2'd3, 4'b0, 2'd2, 1'b0, 0, 1, "R9");
    send(32'h0, 8'd0, 3'd3, 2'd3, 4'b0, 2'd0, 1'b0, 1, 1, "R10");
    send(32'h0, 8'd0, 3'd3, 2'd1, 4'b0, 2'd0, 1'b0, 0, 0, "R10");
    for (int i = 0; i < 10; i++)
      send(32'h0, 8'd0, 3'd3, 2'd3, 4'b0, 2'd0, 1'b0, 1, 1, "R11");
    check(err_count == 3'd7, "R11", "saturate", longint'(err_count), 7);
    do_reset();
    for (int i = 0; i < 300; i++) begin
      logic [7:0] l;
      logic [AW-1:0] a;
      case ($urandom % 6)
        0: l = 8'd0; 1: l = 8'd1; 2: l = 8'd3; 3: l = 8'd7; 4: l = 8'd15;
        default: l = 8'($urandom);
      endcase
      a = $urandom;
      if ($urandom % 2 == 0) a = a & ~32'h7F;
      send(a, l, 3'($urandom % 2 == 0 ? 3 : $urandom), 2'($urandom),
           ($urandom % 2 == 0) ? 4'b0011 : 4'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 4 != 0), "R1");
      if (i % 5 == 4) do_reset();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule